// File: doc/BRIEF.md
# Address Bus Request Controller

This block produces the bus-request output of one master on a shared, arbitrated, split-transaction address bus. Each cycle it looks at whether a transaction is waiting, whether that transaction was withdrawn internally, the state of the arbiter's grant, the address-bus-busy line, the address-retry line, and two flags. The first flag says this master drove the retry itself. The second says a snoop copyback is owed. From these it decides whether the request is driven high, driven low or released (output enable low).

When the controller accepts a grant, it pulses a start strobe so that the address-tenure logic can begin. That tenure logic, the arbiter, the snooper and the data bus are outside the block. Request, enable and start are registered and active-high. Any inversion for an active-low pad is done by the surrounding logic.

Top module: `addrReqCtrl`

## Requirements
- R1: While enabled and no other rule below applies, `reqOut` in cycle t+1 equals `opPending` in cycle t, so a request can begin on any cycle.
- R2: When the master is parked on an idle bus (`grantIn`=1 and `busBusy`=0 in cycle t), `reqOut` is 0 in cycle t+1.
- R3: A grant is accepted in cycle t when the block is enabled, `checkStop`=0, `grantIn`=1, `busBusy`=0, `retryIn`=0 and `opPending`=1. `tenureStart` is then 1 for exactly cycle t+1 and is 0 in every other cycle.
- R4: After an accepted grant in cycle t, `reqOut` is 0 in cycles t+1 through t+NEG_CYCLES (default 1), even if another transaction is pending.
- R5: After `retryIn`=1 in cycle t, `reqOut` is 0 in cycles t+1 through t+NEG_CYCLES. The exception is when `retryByMe` and `needCopyback` are both 1 in cycle t; then R1 and R2 decide the request.
- R6: `cancelReq`=1 in cycle t forces `reqOut` to 0 in cycle t+1. When the same cycle also accepts a grant, the cancel has no effect and `tenureStart` still pulses.
- R7: While `rstN`=0, `reqOe`, `reqOut` and `tenureStart` are 0 at once. `checkStop`=1 in cycle t makes all three 0 in cycle t+1 and clears any pending negation window.
- R8: The first cycle in which `reqOe` returns to 1 after reset or checkstop has `reqOut`=0. A request needs `opPending` seen while enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Hard reset, active low, asynchronous |
| checkStop | input | 1 | Checkstop condition, releases the request line |
| opPending | input | 1 | A bus operation is waiting for the address bus |
| cancelReq | input | 1 | Internal withdrawal of the pending request |
| grantIn | input | 1 | Arbiter grant to this master |
| busBusy | input | 1 | Address bus busy |
| retryIn | input | 1 | Address retry seen on the bus |
| retryByMe | input | 1 | This master drove the current retry |
| needCopyback | input | 1 | This master owes a snoop copyback |
| reqOut | output | 1 | Registered bus request, active high |
| reqOe | output | 1 | Output enable for the request pad, 0 means high impedance |
| tenureStart | output | 1 | One-cycle pulse after an accepted grant |

## Verification
The hardest case to reach is the copyback exception. It needs a retry cycle with both ownership flags set, a pending operation, and no parked-idle grant. Only in that combination does the request survive a retry. Uniform random inputs seldom produce it together with a check of the following cycle. The bench therefore drives that combination directly. It also drives the case where a cancel and an accepted grant fall in the same cycle. A long random run with biased probabilities then mixes retries, grants, cancels and rare checkstops against a cycle model built from the requirements.

// File: rtl/addrReqPkg.sv
package addrReqPkg;

  // Strobes from control to datapath: next-cycle values of the registered outputs
  typedef struct packed {
    logic enNext;
    logic reqNext;
    logic startNext;
  } reqStrobe_t;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_RUN  = 2'd1,
    MODE_HOLD = 2'd2
  } reqMode_t;

endpackage

// File: rtl/addrReqCtl.sv
module addrReqCtl
  import addrReqPkg::*;
#(
  parameter int NEG_CYCLES = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       checkStop,
  input  logic       opPending,
  input  logic       cancelReq,
  input  logic       grantIn,
  input  logic       busBusy,
  input  logic       retryIn,
  input  logic       retryByMe,
  input  logic       needCopyback,
  output reqStrobe_t strb
);

  localparam int CW        = $clog2(NEG_CYCLES + 1);
  localparam int HOLD_LOAD = NEG_CYCLES - 1;

  reqMode_t       mode, modeNext;
  logic [CW-1:0]  holdCnt, holdNext;
  logic           qualGrant;
  logic           retryForce;
  logic           parkedIdle;
  logic           holdLast;

  // Grant accepted only when enabled and a transaction is waiting
  assign qualGrant  = (mode != MODE_OFF) & grantIn & ~busBusy & ~retryIn & opPending;
  // Retry forces negation unless this master retried and owes a copyback
  assign retryForce = retryIn & ~(retryByMe & needCopyback);
  assign parkedIdle = grantIn & ~busBusy;
  assign holdLast   = (holdCnt == CW'(1));

  always_comb begin
    strb     = '0;
    modeNext = mode;
    holdNext = holdCnt;
    if (checkStop) begin
      modeNext = MODE_OFF;
      holdNext = '0;
    end else begin
      unique case (mode)
        MODE_OFF: begin
          // first enabled cycle always starts with the request low
          strb.enNext = 1'b1;
          modeNext    = MODE_RUN;
        end
        default: begin
          strb.enNext     = 1'b1;
          strb.startNext  = qualGrant;
          if (qualGrant || retryForce) begin
            holdNext = CW'(HOLD_LOAD);
            modeNext = (HOLD_LOAD != 0) ? MODE_HOLD : MODE_RUN;
          end else if (mode == MODE_HOLD) begin
            holdNext = holdCnt - CW'(1);
            modeNext = holdLast ? MODE_RUN : MODE_HOLD;
          end else begin
            strb.reqNext = opPending & ~parkedIdle & ~cancelReq;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode    <= MODE_OFF;
      holdCnt <= '0;
    end else begin
      mode    <= modeNext;
      holdCnt <= holdNext;
    end
  end

endmodule

// File: rtl/addrReqDp.sv
module addrReqDp
  import addrReqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  reqStrobe_t strb,
  output logic       reqOut,
  output logic       reqOe,
  output logic       tenureStart
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqOe       <= 1'b0;
      reqOut      <= 1'b0;
      tenureStart <= 1'b0;
    end else begin
      reqOe       <= strb.enNext;
      reqOut      <= strb.enNext & strb.reqNext;
      tenureStart <= strb.enNext & strb.startNext;
    end
  end

endmodule

// File: rtl/addrReqCtrl.sv
module addrReqCtrl
  import addrReqPkg::*;
#(
  parameter int NEG_CYCLES = 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic checkStop,
  input  logic opPending,
  input  logic cancelReq,
  input  logic grantIn,
  input  logic busBusy,
  input  logic retryIn,
  input  logic retryByMe,
  input  logic needCopyback,
  output logic reqOut,
  output logic reqOe,
  output logic tenureStart
);

  reqStrobe_t strb;

  addrReqCtl #(.NEG_CYCLES(NEG_CYCLES)) u_ctl (
    .clk(clk), .rstN(rstN), .checkStop(checkStop), .opPending(opPending),
    .cancelReq(cancelReq), .grantIn(grantIn), .busBusy(busBusy),
    .retryIn(retryIn), .retryByMe(retryByMe), .needCopyback(needCopyback),
    .strb(strb)
  );

  addrReqDp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .reqOut(reqOut), .reqOe(reqOe), .tenureStart(tenureStart)
  );

endmodule

// File: rtl/addrReqChk.sv
module addrReqChk (
  input logic clk,
  input logic rstN,
  input logic checkStop,
  input logic opPending,
  input logic cancelReq,
  input logic grantIn,
  input logic busBusy,
  input logic retryIn,
  input logic retryByMe,
  input logic needCopyback,
  input logic reqOut,
  input logic reqOe,
  input logic tenureStart
);

  a_r1_no_pending_no_req: assert property (@(posedge clk) disable iff (!rstN)
    !opPending |=> !reqOut);

  a_r2_parked_idle: assert property (@(posedge clk) disable iff (!rstN)
    (grantIn && !busBusy) |=> !reqOut);

  a_r3_start_cause: assert property (@(posedge clk) disable iff (!rstN)
    tenureStart |-> $past(reqOe && !checkStop && grantIn && !busBusy && !retryIn && opPending));

  a_r4_neg_after_grant: assert property (@(posedge clk) disable iff (!rstN)
    tenureStart |-> !reqOut);

  a_r5_retry_neg: assert property (@(posedge clk) disable iff (!rstN)
    (retryIn && !(retryByMe && needCopyback)) |=> !reqOut);

  a_r6_cancel: assert property (@(posedge clk) disable iff (!rstN)
    cancelReq |=> !reqOut);

  a_r7_checkstop: assert property (@(posedge clk) disable iff (!rstN)
    checkStop |=> (!reqOe && !reqOut && !tenureStart));

  a_r8_enable_low_first: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqOe) |-> !reqOut);

  always_comb begin
    if (rstN && !reqOe) begin
      a_r7_off_quiet: assert (!reqOut && !tenureStart);
    end
  end

endmodule

bind addrReqCtrl addrReqChk u_chk (
  .clk(clk), .rstN(rstN), .checkStop(checkStop), .opPending(opPending),
  .cancelReq(cancelReq), .grantIn(grantIn), .busBusy(busBusy),
  .retryIn(retryIn), .retryByMe(retryByMe), .needCopyback(needCopyback),
  .reqOut(reqOut), .reqOe(reqOe), .tenureStart(tenureStart)
);

// File: tb/addrReqCtrl_bench.sv
`timescale 1ns/1ps
module addrReqCtrl_bench;

  localparam int NEG = 1;

  logic clk = 1'b0;
  logic rstN;
  logic checkStop, opPending, cancelReq, grantIn, busBusy;
  logic retryIn, retryByMe, needCopyback;
  logic reqOut, reqOe, tenureStart;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // model state (values expected on the outputs after the next edge)
  logic mReq, mOe, mStart;
  int   mHold;
  string whyReq;

  always #5 clk = ~clk;

  addrReqCtrl #(.NEG_CYCLES(NEG)) u_addrReqCtrl (
    .clk(clk), .rstN(rstN), .checkStop(checkStop), .opPending(opPending),
    .cancelReq(cancelReq), .grantIn(grantIn), .busBusy(busBusy),
    .retryIn(retryIn), .retryByMe(retryByMe), .needCopyback(needCopyback),
    .reqOut(reqOut), .reqOe(reqOe), .tenureStart(tenureStart)
  );

  function automatic bit acceptGrant(logic oe, logic cs, logic g, logic b, logic r, logic p);
    return oe && !cs && g && !b && !r && p;
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Advance the model by one edge using the inputs currently applied
  task automatic modelStep();
    logic nReq, nOe, nStart;
    int nHold;
    bit qg, rf;
    nReq = 0; nStart = 0; nHold = 0; nOe = 1;
    if (checkStop) begin
      nOe = 0; whyReq = "R7";
    end else if (!mOe) begin
      whyReq = "R8";
    end else begin
      qg = acceptGrant(mOe, checkStop, grantIn, busBusy, retryIn, opPending);
      rf = retryIn && !(retryByMe && needCopyback);
      nStart = qg;
      if (qg) begin nHold = NEG - 1; whyReq = "R4"; end
      else if (rf) begin nHold = NEG - 1; whyReq = "R5"; end
      else if (mHold > 0) begin nHold = mHold - 1; whyReq = "R4"; end
      else if (grantIn && !busBusy) whyReq = "R2";
      else if (cancelReq) whyReq = "R6";
      else begin nReq = opPending; whyReq = "R1"; end
    end
    mReq = nReq; mOe = nOe; mStart = nStart; mHold = nHold;
  endtask

  task automatic drive(logic cs, logic p, logic c, logic g, logic b,
                       logic r, logic rb, logic cb);
    checkStop = cs; opPending = p; cancelReq = c; grantIn = g;
    busBusy = b; retryIn = r; retryByMe = rb; needCopyback = cb;
  endtask

  // Apply inputs, step one clock, compare outputs at the falling edge
  task automatic cycle();
    modelStep();
    @(negedge clk);
    check({whyReq, " reqOut"}, reqOut, mReq);
    check("R7 reqOe", reqOe, mOe);
    check("R3 tenureStart", tenureStart, mStart);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rstN = 1'b0;
    drive(0, 1, 0, 0, 0, 0, 0, 0);
    mReq = 0; mOe = 0; mStart = 0; mHold = 0;
    repeat (3) @(negedge clk);
    check("R7 reset reqOe", reqOe, 1'b0);
    check("R7 reset reqOut", reqOut, 1'b0);
    check("R7 reset tenureStart", tenureStart, 1'b0);
    rstN = 1'b1;

    // R8: first enabled cycle is low even with a pending op
    cycle();
    check("R8 first enable", reqOut, 1'b0);
    cycle();
    check("R1 request asserted", reqOut, 1'b1);

    // R2: parked on idle bus, no operation yet -> request low
    drive(0, 0, 0, 1, 0, 0, 0, 0); cycle();
    check("R2 parked idle", reqOut, 1'b0);

    // R3/R4: accepted grant -> start pulse and forced negation
    drive(0, 1, 0, 1, 0, 0, 0, 0); cycle();
    check("R3 start pulse", tenureStart, 1'b1);
    check("R4 negated after grant", reqOut, 1'b0);
    drive(0, 1, 0, 0, 1, 0, 0, 0); cycle();
    check("R3 single pulse", tenureStart, 1'b0);
    check("R1 re-request", reqOut, 1'b1);

    // R5: retry by other master -> negation
    drive(0, 1, 0, 0, 1, 1, 0, 0); cycle();
    check("R5 retry negation", reqOut, 1'b0);
    // R5 exception: own retry with copyback keeps the request
    drive(0, 1, 0, 0, 1, 1, 1, 1); cycle();
    check("R5 copyback exception", reqOut, 1'b1);
    // own retry without copyback still negates
    drive(0, 1, 0, 0, 1, 1, 1, 0); cycle();
    check("R5 own retry no copyback", reqOut, 1'b0);

    // R6: cancel withdraws
    drive(0, 1, 0, 0, 1, 0, 0, 0); cycle();
    drive(0, 1, 1, 0, 1, 0, 0, 0); cycle();
    check("R6 cancel withdraws", reqOut, 1'b0);
    // R6: cancel with accepted grant has no effect
    drive(0, 1, 1, 1, 0, 0, 0, 0); cycle();
    check("R6 grant beats cancel", tenureStart, 1'b1);

    // R7: checkstop releases the line; R8 on recovery
    drive(1, 1, 0, 0, 1, 0, 0, 0); cycle();
    check("R7 checkstop oe", reqOe, 1'b0);
    drive(0, 1, 0, 0, 1, 0, 0, 0); cycle();
    check("R8 recover low", reqOut, 1'b0);
    check("R8 recover oe", reqOe, 1'b1);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      drive(($urandom % 50) == 0, ($urandom % 4) != 0, ($urandom % 8) == 0,
            ($urandom % 3) == 0, ($urandom % 2) == 0, ($urandom % 6) == 0,
            ($urandom % 2) == 0, ($urandom % 2) == 0);
      cycle();
    end

    // R7: asynchronous reset mid-run
    #2 rstN = 1'b0;
    #1;
    check("R7 async reset reqOe", reqOe, 1'b0);
    check("R7 async reset reqOut", reqOut, 1'b0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule